// File: doc/BRIEF.md
# I2C Read-Only Target with Host-Paced Clock Holding

This block is a target device on a two-wire I2C bus that serves read transfers from a controller using 7-bit addressing. It recovers the bus lines into the system clock domain and detects Start and Stop conditions. It shifts in the address byte and compares its upper seven bits with an address supplied by the host. If the address matches and the direction bit asks for a read, the block acknowledges and then sends one data byte for each transfer.

The host side uses single-cycle strobes. One strobe writes the transmit byte, another releases the clock and a third clears the interrupt. The host reads a buffer output, a read-direction flag, a buffer-full flag and an interrupt flag. After the address acknowledge, and after every byte the controller acknowledges, the block pulls SCL low. SCL stays low until the host has written the next byte and then asked for release. This gives slow host software the time it needs. Both lines are open-drain. Each is modelled as an output that, when high, pulls the line low.

Top module: `i2c_read_slave`

## Requirements
- R1: An SDA fall while SCL is high (Start) begins address reception from any state. An SDA rise while SCL is high (Stop) releases both lines and returns the block to idle, so later clocks are ignored until the next Start.
- R2: The address byte arrives MSB first: bits 7:1 hold the address and bit 0 holds the direction. If bits 7:1 equal `own_addr` and bit 0 is 1, the block does all of the following:
  - it sets `rw_flag`;
  - it copies the whole byte to `host_rdata`;
  - it pulls SDA low for the ninth clock;
  - it pulls SCL low after that clock falls.
- R3: If the address does not match, or bit 0 is 0, the block drives neither line until the next Start.
- R4: A `host_wr` pulse while SCL is held does three things: it loads `host_rdata`, loads the transmit shift register and sets `buf_full`. A `host_wr` at any other time has no effect.
- R5: A `host_release` pulse frees SCL only if a `host_wr` came earlier in the same hold. Otherwise the pulse is ignored and SCL stays low.
- R6: Data bits go out MSB first. SDA changes only after SCL falls, so it is stable while SCL is high.
- R7: The controller's acknowledge is sampled at the rising edge of the ninth clock of a data byte. If SDA is low (ACK), SCL is held low again after that clock falls.
- R8: If the sampled ninth bit is high (NACK), the block does all of the following:
  - it releases both lines;
  - it clears `rw_flag` and `buf_full`;
  - it ignores the bus until a Start.
- R9: `irq` is set when the ninth clock of the address byte falls and when the ninth clock of every data byte falls. It stays set until an `irq_clr` pulse.
- R10: `buf_full` clears once all eight bits of the byte have been shifted out, that is, after the eighth falling edge of the data byte.
- R11: After reset both lines are released, the flags are 0 and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr | input | DATA_W-1 | Address this target answers to |
| host_wr | input | 1 | Strobe: write transmit byte |
| host_wdata | input | DATA_W | Transmit byte |
| host_release | input | 1 | Strobe: request SCL release |
| irq_clr | input | 1 | Strobe: clear interrupt flag |
| host_rdata | output | DATA_W | Buffer: received address or last written byte |
| rw_flag | output | 1 | Read transfer in progress |
| buf_full | output | 1 | Buffer written and not yet sent |
| irq | output | 1 | Byte-complete interrupt flag |
| scl_pull | output | 1 | High pulls SCL low |
| sda_pull | output | 1 | High pulls SDA low |

## Verification
The embedded assertions check on every cycle the properties that hold at all times:
- Both lines stay quiet while the block is idle.
- SDA holds steady while SCL is high during transmission.
- SCL cannot be released without a prior buffer write.
- The interrupt flag stays set until it is cleared.
- SCL is held again after an ACK and released after a NACK.
- Writes made outside a hold leave the buffer untouched.

Only the bench scenarios can show the rest:
- the actual bit order on the bus;
- address filtering for a wrong address and for a write direction;
- recovery through a repeated Start and an early Stop;
- exactly when `buf_full` clears relative to the eighth and ninth clocks.

// File: rtl/i2c_read_slave.sv
module i2c_read_slave #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_release,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              rw_flag,
  output logic              buf_full,
  output logic              irq,
  output logic              scl_pull,
  output logic              sda_pull
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_HOLD, S_TX, S_MACK} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  st_t st;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] shreg, addr_byte;
  logic wr_seen, ack_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1; sda_sync <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q <= scl_sync[1];
      sda_q <= sda_sync[1];
    end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_c   = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  assign addr_byte = {shreg[DATA_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; shreg <= '0; host_rdata <= '0;
      rw_flag <= 1'b0; buf_full <= 1'b0; irq <= 1'b0;
      scl_pull <= 1'b0; sda_pull <= 1'b0; wr_seen <= 1'b0; ack_q <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (stop_c) begin
        st <= S_IDLE; sda_pull <= 1'b0; scl_pull <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_pull <= 1'b0; scl_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            shreg <= addr_byte;
            if (cnt == LAST) begin
              cnt <= '0;
              if (addr_byte[DATA_W-1:1] == own_addr && addr_byte[0]) begin
                st <= S_AACK; rw_flag <= 1'b1; host_rdata <= addr_byte;
              end else st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          S_AACK: if (scl_fall) begin
            if (cnt == '0) begin
              sda_pull <= 1'b1; cnt <= 1;
            end else begin
              sda_pull <= 1'b0; scl_pull <= 1'b1; irq <= 1'b1;
              wr_seen <= 1'b0; st <= S_HOLD;
            end
          end
          S_HOLD: begin
            if (host_wr) begin
              host_rdata <= host_wdata; shreg <= host_wdata;
              buf_full <= 1'b1; wr_seen <= 1'b1;
            end else if (host_release && wr_seen) begin
              scl_pull <= 1'b0; sda_pull <= ~shreg[DATA_W-1];
              cnt <= '0; st <= S_TX;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == LAST) begin
              sda_pull <= 1'b0; buf_full <= 1'b0; st <= S_MACK;
            end else begin
              sda_pull <= ~shreg[DATA_W-2];
              shreg <= shreg << 1;
              cnt <= cnt + 1'b1;
            end
          end
          S_MACK: begin
            if (scl_rise) ack_q <= ~sda_s;
            if (scl_fall) begin
              irq <= 1'b1;
              if (ack_q) begin
                scl_pull <= 1'b1; wr_seen <= 1'b0; st <= S_HOLD;
              end else begin
                st <= S_IDLE; rw_flag <= 1'b0; buf_full <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !scl_pull && !sda_pull); // R3
  AST_TX_SDA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && scl_s && scl_q) |=> $stable(sda_pull)); // R6
  AST_RELEASE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !wr_seen && !start_c && !stop_c) |=> scl_pull); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R9
  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK && scl_fall && ack_q && !start_c && !stop_c) |=> scl_pull); // R7
  AST_NACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK && scl_fall && !ack_q && !start_c && !stop_c) |=> !scl_pull && !sda_pull && !rw_flag); // R8
  AST_WR_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (st == S_IDLE || st == S_TX || st == S_MACK)) |=> $stable(host_rdata)); // R4
endmodule

// File: tb/i2c_read_slave_tb.sv
module i2c_read_slave_tb;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h2A;
  localparam logic [8:0] VEC [4] = '{ {1'b0, 8'hA5}, {1'b0, 8'h3C}, {1'b0, 8'h80}, {1'b1, 8'h5E} };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic host_wr = 0, host_release = 0, irq_clr = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic rw_flag, buf_full, irq, scl_pull, sda_pull;
  logic scl_line, sda_line;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;
  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  i2c_read_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .own_addr(OWN),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_release(host_release), .irq_clr(irq_clr),
    .host_rdata(host_rdata), .rw_flag(rw_flag), .buf_full(buf_full), .irq(irq),
    .scl_pull(scl_pull), .sda_pull(sda_pull));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask

  task automatic clk_bit(input logic b, output logic s, output logic stab);
    logic s1;
    sda_m = b; tick(H); scl_m = 1; tick(2);
    s1 = sda_line; tick(H - 4);
    s = sda_line; stab = (s1 == s);
    tick(2); scl_m = 0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s, st;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s, st);
    clk_bit(1'b1, s, st);
    acked = !s;
  endtask

  task automatic read8(output logic [7:0] d, output logic stable_all);
    logic s, st;
    stable_all = 1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s, st);
      d[i] = s;
      stable_all &= st;
    end
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    host_wdata = d; host_wr = 1; tick(1); host_wr = 0; tick(2);
  endtask

  task automatic pulse_rel();
    host_release = 1; tick(1); host_release = 0; tick(2);
  endtask

  task automatic pulse_clr();
    irq_clr = 1; tick(1); irq_clr = 0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack, stab, s, st;
    logic [7:0] d;
    tick(5);
    check("R11 scl_pull", scl_pull, 0);
    check("R11 sda_pull", sda_pull, 0);
    check("R11 flags", {rw_flag, buf_full, irq}, 0);
    check("R11 rdata", host_rdata, 0);
    rst_n = 1; tick(5);

    pulse_wr(8'hEE);
    check("R4 write in idle ignored rdata", host_rdata, 0);
    check("R4 write in idle ignored bf", buf_full, 0);

    bus_start(); send_byte({7'h2B, 1'b1}, ack);
    check("R3 wrong address no ack", ack, 0);
    check("R3 wrong address lines", {scl_pull, sda_pull, irq}, 0);
    bus_stop();
    bus_start(); send_byte({OWN, 1'b0}, ack);
    check("R3 write direction no ack", ack, 0);
    check("R3 write direction lines", {scl_pull, rw_flag}, 0);
    bus_stop();

    bus_start(); send_byte({OWN, 1'b1}, ack);
    check("R2 ack", ack, 1);
    check("R2 rw_flag", rw_flag, 1);
    check("R2 rdata", host_rdata, {OWN, 1'b1});
    check("R2 scl held", scl_pull, 1);
    check("R9 irq after address", irq, 1);
    tick(40);
    check("R9 irq sticky", irq, 1);
    pulse_clr();
    check("R9 irq cleared", irq, 0);
    pulse_rel(); tick(4);
    check("R5 release without write ignored", scl_pull, 1);

    for (int v = 0; v < 4; v++) begin
      pulse_wr(VEC[v][7:0]);
      check("R4 buf_full set", buf_full, 1);
      check("R4 rdata loaded", host_rdata, VEC[v][7:0]);
      pulse_rel();
      check("R5 release after write", scl_pull, 0);
      read8(d, stab);
      check("R6 data msb first", d, VEC[v][7:0]);
      check("R6 sda stable while scl high", stab, 1);
      check("R10 buf_full cleared after 8 bits", buf_full, 0);
      clk_bit(VEC[v][8], s, st);
      check("R9 irq after data byte", irq, 1);
      if (!VEC[v][8]) check("R7 scl held after ack", scl_pull, 1);
      else begin
        check("R8 lines freed after nack", {scl_pull, sda_pull}, 0);
        check("R8 status cleared after nack", {rw_flag, buf_full}, 0);
      end
      pulse_clr();
    end
    send_byte({OWN, 1'b1}, ack);
    check("R8 bus ignored until start", ack, 0);
    bus_stop();

    bus_start(); clk_bit(0, s, st); clk_bit(1, s, st); clk_bit(0, s, st); clk_bit(1, s, st);
    bus_stop();
    send_byte({OWN, 1'b1}, ack);
    check("R1 stop returns to idle", ack, 0);
    bus_stop();

    bus_start(); clk_bit(0, s, st); clk_bit(1, s, st); clk_bit(0, s, st);
    bus_start(); send_byte({OWN, 1'b1}, ack);
    check("R1 repeated start restarts address", ack, 1);
    pulse_wr(8'h77); pulse_rel();
    read8(d, stab);
    check("R6 byte after repeated start", d, 8'h77);
    clk_bit(1'b1, s, st);
    bus_stop();
    check("R1 lines free after stop", {scl_pull, sda_pull}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule